// File: doc/BRIEF.md
# Serial port host register bank

This block is the processor-facing register file of a byte-wide serial port. A host addresses eight byte registers through a 3-bit offset with separate read and write strobes. Behind the data offset sit two 128-entry byte queues: a receive queue that the line side fills through a push port, and a transmit queue that the line side empties through a pop port. Baud-rate generation, serialization and interrupt arbitration belong to neighbouring blocks. They take the divisor, line control, modem control, interrupt enable and queue control values from the outputs of this block.

The bank keeps the line status byte current as the queues change. It raises data-ready on a receive push and clears it when a host read empties the receive queue. It clears the two transmitter-empty bits on a host write and sets them again when the line side takes the last byte. When a byte arrives at a full receive queue, the byte is dropped and the overrun bit is set; a host read of the status byte clears that bit. Writes to the queue control register flush either queue or both. Bit 7 of the line control register swaps offsets 0 and 1 over to the two divisor bytes.

Top module: `uart_regbank`

Offset map: 0 = receive/transmit data (divisor low byte when bit 7 of line control is 1), 1 = interrupt enable (divisor high byte when bit 7 of line control is 1), 2 = read identification / write queue control, 3 = line control, 4 = modem control, 5 = line status, 6 = modem status, 7 = scratch.

## Requirements
- R1: With line control bit 7 set, offset 0 reads and writes the divisor low byte and offset 1 reads and writes the divisor high byte (divisor_o = {high, low}), and the data queues and the interrupt enable byte are untouched. With bit 7 clear, offset 0 is the data queue and offset 1 is interrupt enable.
- R2: After reset: interrupt enable 0x03, identification 0x01, queue control 0xC0, line control 0x03, modem control 0x00, line status 0x60, modem status 0x00, scratch 0x00, divisor low 0x01, divisor high 0x00, both queue counts 0.
- R3: Each queue holds 128 bytes, and its count runs from 0 to 128 so that full and empty are distinct. A push and a pop in the same cycle leave the count unchanged. A push into a full queue is accepted when a pop happens in the same cycle.
- R4: A receive push into a full queue with no same-cycle pop drops the byte and sets line status bit 1 (overrun). A host read of line status returns the current value and then clears bit 1, unless an overrun occurs in that same cycle.
- R5: Every receive push sets line status bit 0 (data ready). The bit clears when a host read of offset 0 takes the last byte from the receive queue.
- R6: A host write to offset 0 (line control bit 7 clear) clears line status bits 5 and 6. Both bits set again when a line-side pop takes the last byte from the transmit queue.
- R7: A queue control write with bit 0 clear empties both queues and clears stored bit 0; the other stored bits are kept. A flush leaves the line status byte unchanged.
- R8: A queue control write with bit 0 set stores the byte with bits 1 and 2 forced to 0. Bit 1 flushes the receive queue and bit 2 flushes the transmit queue.
- R9: Line status (offset 5) and modem status (offset 6) are writable as whole bytes. Scratch (offset 7) stores and returns any byte.
- R10: A host read of offset 0 with line control bit 7 clear and an empty receive queue returns 0x00 and leaves the queue count at 0.
- R11: A read of offset 2 always returns 0x01. A write to offset 2 goes to queue control only.
- R12: Both queues deliver bytes in the order they were accepted, and dropped bytes never appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 3 | Register offset |
| host_rd | input | 1 | Read strobe, side effects at the clock edge |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for the addressed offset, combinational |
| rx_push | input | 1 | Line side pushes a received byte |
| rx_data | input | 8 | Received byte |
| tx_pop | input | 1 | Line side takes the head transmit byte |
| tx_data | output | 8 | Head of the transmit queue |
| tx_valid | output | 1 | Transmit queue not empty |
| rx_count | output | 8 | Receive queue occupancy, 0 to 128 |
| tx_count | output | 8 | Transmit queue occupancy, 0 to 128 |
| divisor_o | output | 16 | Divisor {high, low} |
| line_ctrl_o | output | 8 | Line control byte |
| modem_ctrl_o | output | 8 | Modem control byte |
| irq_en_o | output | 8 | Interrupt enable byte |
| fifo_ctrl_o | output | 8 | Stored queue control byte |
| line_status_o | output | 8 | Line status byte |

## Verification
The receive path is tried with a short burst, a complete fill to 128 followed by a dropped extra byte, a push coincident with a host read while full, and a push coincident with a read at occupancy one. Together these separate a correct full test from an off-by-one one, and they separate dropping from overwriting, which shows in the scoreboard order. The transmit path is filled by the host and drained by a line-side monitor against an ordered scoreboard. Status bits are read back after each of these steps. Queue control writes with enable clear, receive-only flush and transmit-only flush tell apart which queue each bit empties, and they show that a flush leaves the status byte alone.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;
    localparam int ADDR_W = 3;
    localparam int BYTE_W = 8;

    localparam int LSR_DR   = 0;
    localparam int LSR_OE   = 1;
    localparam int LSR_THRE = 5;
    localparam int LSR_TEMT = 6;
    localparam int LCR_BANK = 7;
    localparam int FCR_EN   = 0;
    localparam int FCR_RXCL = 1;
    localparam int FCR_TXCL = 2;

    localparam logic [BYTE_W-1:0] IDENT_IDLE = 8'h01;

    typedef enum logic [3:0] {
        SEL_DATA, SEL_DLL, SEL_IER, SEL_DLM, SEL_IDENT,
        SEL_LCR, SEL_MCR, SEL_LSR, SEL_MSR, SEL_SCR
    } reg_sel_e;

    typedef struct packed {
        logic [BYTE_W-1:0] ier;
        logic [BYTE_W-1:0] fcr;
        logic [BYTE_W-1:0] lcr;
        logic [BYTE_W-1:0] mcr;
        logic [BYTE_W-1:0] lsr;
        logic [BYTE_W-1:0] msr;
        logic [BYTE_W-1:0] scr;
        logic [BYTE_W-1:0] dll;
        logic [BYTE_W-1:0] dlm;
    } regs_t;

    localparam regs_t REGS_RST = '{
        ier: 8'h03, fcr: 8'hC0, lcr: 8'h03, mcr: 8'h00, lsr: 8'h60,
        msr: 8'h00, scr: 8'h00, dll: 8'h01, dlm: 8'h00
    };
endpackage

// File: rtl/uart_rb_decode.sv
module uart_rb_decode
    import uart_rb_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              bank,
    output reg_sel_e          sel
);
    always_comb begin
        case (addr)
            3'd0:    sel = bank ? SEL_DLL : SEL_DATA;
            3'd1:    sel = bank ? SEL_DLM : SEL_IER;
            3'd2:    sel = SEL_IDENT;
            3'd3:    sel = SEL_LCR;
            3'd4:    sel = SEL_MCR;
            3'd5:    sel = SEL_LSR;
            3'd6:    sel = SEL_MSR;
            default: sel = SEL_SCR;
        endcase
    end
endmodule

// File: rtl/uart_rb_fifo.sv
module uart_rb_fifo #(
    parameter int DEPTH = 128,
    parameter int WIDTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head_data,
    output logic [CW-1:0]    count,
    output logic             push_ok,
    output logic             pop_ok
);
    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t q, d;
    logic [WIDTH-1:0] mem [DEPTH];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        pop_ok  = pop && !flush && (q.cnt != '0);
        push_ok = push && !flush && ((q.cnt != CW'(DEPTH)) || pop_ok);
        d = q;
        if (flush) begin
            d = '0;
        end else begin
            if (push_ok) d.wr = bump(q.wr);
            if (pop_ok)  d.rd = bump(q.rd);
            case ({push_ok, pop_ok})
                2'b10:   d.cnt = q.cnt + CW'(1);
                2'b01:   d.cnt = q.cnt - CW'(1);
                default: d.cnt = q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[q.wr] <= push_data;
    end

    assign head_data = mem[q.rd];
    assign count     = q.cnt;
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
    import uart_rb_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    input  logic              rx_push,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              tx_pop,
    output logic [BYTE_W-1:0] tx_data,
    output logic              tx_valid,
    output logic [CW-1:0]     rx_count,
    output logic [CW-1:0]     tx_count,
    output logic [2*BYTE_W-1:0] divisor_o,
    output logic [BYTE_W-1:0] line_ctrl_o,
    output logic [BYTE_W-1:0] modem_ctrl_o,
    output logic [BYTE_W-1:0] irq_en_o,
    output logic [BYTE_W-1:0] fifo_ctrl_o,
    output logic [BYTE_W-1:0] line_status_o
);
    regs_t      regs_q, regs_d;
    reg_sel_e   sel;
    logic       host_rx_pop, host_tx_push, ctl_wr;
    logic       rx_flush, tx_flush;
    logic       rx_push_ok, rx_pop_ok, tx_push_ok, tx_pop_ok;
    logic       rx_went_empty, tx_went_empty, rx_drop;
    logic [BYTE_W-1:0] rx_head;

    uart_rb_decode dec_i (
        .addr (host_addr),
        .bank (regs_q.lcr[LCR_BANK]),
        .sel  (sel)
    );

    assign host_rx_pop  = host_rd && (sel == SEL_DATA);
    assign host_tx_push = host_wr && (sel == SEL_DATA);
    assign ctl_wr       = host_wr && (sel == SEL_IDENT);
    assign rx_flush     = ctl_wr && (!host_wdata[FCR_EN] || host_wdata[FCR_RXCL]);
    assign tx_flush     = ctl_wr && (!host_wdata[FCR_EN] || host_wdata[FCR_TXCL]);

    uart_rb_fifo #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) rxq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (rx_flush),
        .push      (rx_push),
        .push_data (rx_data),
        .pop       (host_rx_pop),
        .head_data (rx_head),
        .count     (rx_count),
        .push_ok   (rx_push_ok),
        .pop_ok    (rx_pop_ok)
    );

    uart_rb_fifo #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) txq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (tx_flush),
        .push      (host_tx_push),
        .push_data (host_wdata),
        .pop       (tx_pop),
        .head_data (tx_data),
        .count     (tx_count),
        .push_ok   (tx_push_ok),
        .pop_ok    (tx_pop_ok)
    );

    assign rx_went_empty = rx_pop_ok && !rx_push_ok && (rx_count == CW'(1));
    assign tx_went_empty = tx_pop_ok && !tx_push_ok && (tx_count == CW'(1));
    assign rx_drop       = rx_push && !rx_push_ok && !rx_flush;

    always_comb begin
        regs_d = regs_q;
        if (host_wr) begin
            case (sel)
                SEL_DLL: regs_d.dll = host_wdata;
                SEL_DLM: regs_d.dlm = host_wdata;
                SEL_IER: regs_d.ier = host_wdata;
                SEL_LCR: regs_d.lcr = host_wdata;
                SEL_MCR: regs_d.mcr = host_wdata;
                SEL_LSR: regs_d.lsr = host_wdata;
                SEL_MSR: regs_d.msr = host_wdata;
                SEL_SCR: regs_d.scr = host_wdata;
                SEL_IDENT: begin
                    if (host_wdata[FCR_EN]) begin
                        regs_d.fcr = host_wdata;
                        regs_d.fcr[FCR_RXCL] = 1'b0;
                        regs_d.fcr[FCR_TXCL] = 1'b0;
                    end else begin
                        regs_d.fcr[FCR_EN] = 1'b0;
                    end
                end
                default: ;
            endcase
        end
        if (host_rd && (sel == SEL_LSR)) regs_d.lsr[LSR_OE] = 1'b0;
        if (rx_went_empty) regs_d.lsr[LSR_DR] = 1'b0;
        if (rx_push)       regs_d.lsr[LSR_DR] = 1'b1;
        if (rx_drop)       regs_d.lsr[LSR_OE] = 1'b1;
        if (tx_went_empty) begin
            regs_d.lsr[LSR_THRE] = 1'b1;
            regs_d.lsr[LSR_TEMT] = 1'b1;
        end
        if (host_tx_push) begin
            regs_d.lsr[LSR_THRE] = 1'b0;
            regs_d.lsr[LSR_TEMT] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= REGS_RST;
        else        regs_q <= regs_d;
    end

    always_comb begin
        case (sel)
            SEL_DATA:  host_rdata = (rx_count != '0) ? rx_head : '0;
            SEL_DLL:   host_rdata = regs_q.dll;
            SEL_DLM:   host_rdata = regs_q.dlm;
            SEL_IER:   host_rdata = regs_q.ier;
            SEL_IDENT: host_rdata = IDENT_IDLE;
            SEL_LCR:   host_rdata = regs_q.lcr;
            SEL_MCR:   host_rdata = regs_q.mcr;
            SEL_LSR:   host_rdata = regs_q.lsr;
            SEL_MSR:   host_rdata = regs_q.msr;
            default:   host_rdata = regs_q.scr;
        endcase
    end

    assign tx_valid      = (tx_count != '0);
    assign divisor_o     = {regs_q.dlm, regs_q.dll};
    assign line_ctrl_o   = regs_q.lcr;
    assign modem_ctrl_o  = regs_q.mcr;
    assign irq_en_o      = regs_q.ier;
    assign fifo_ctrl_o   = regs_q.fcr;
    assign line_status_o = regs_q.lsr;
endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk #(
    parameter int DEPTH = 128,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    host_addr,
    input logic          host_rd,
    input logic          host_wr,
    input logic [7:0]    host_wdata,
    input logic          rx_push,
    input logic [CW-1:0] rx_count,
    input logic [CW-1:0] tx_count,
    input logic [7:0]    line_ctrl_o,
    input logic [7:0]    line_status_o,
    input logic [15:0]   divisor_o
);
    logic host_pops, ctl_write, tx_write;
    assign host_pops = host_rd && (host_addr == 3'd0) && !line_ctrl_o[7];
    assign tx_write  = host_wr && (host_addr == 3'd0) && !line_ctrl_o[7];
    assign ctl_write = host_wr && (host_addr == 3'd2);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count <= CW'(DEPTH)) && (tx_count <= CW'(DEPTH))); // R3

    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == CW'(DEPTH)) && rx_push && !host_pops && !ctl_write
        |=> (rx_count == CW'(DEPTH))); // R3

    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == CW'(DEPTH)) && rx_push && !host_pops && !ctl_write
        |=> line_status_o[1]); // R4

    AST_OVERRUN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd && (host_addr == 3'd5) && !host_wr && !rx_push
        |=> !line_status_o[1]); // R4

    AST_READY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |=> line_status_o[0]); // R5

    AST_TX_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_write |=> !line_status_o[5] && !line_status_o[6]); // R6

    AST_FLUSH_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_write && !host_wdata[0]
        |=> (rx_count == '0) && (tx_count == '0)); // R7

    AST_DIV_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !host_wr |=> $stable(divisor_o)); // R1
endmodule

bind uart_regbank uart_regbank_chk #(.DEPTH(DEPTH)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_addr     (host_addr),
    .host_rd       (host_rd),
    .host_wr       (host_wr),
    .host_wdata    (host_wdata),
    .rx_push       (rx_push),
    .rx_count      (rx_count),
    .tx_count      (tx_count),
    .line_ctrl_o   (line_ctrl_o),
    .line_status_o (line_status_o),
    .divisor_o     (divisor_o)
);

// File: tb/uart_regbank_tb_top.sv
module uart_regbank_tb_top;
    localparam int DEPTH = 128;
    localparam int CW = $clog2(DEPTH) + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    host_addr = '0;
    logic          host_rd = 1'b0;
    logic          host_wr = 1'b0;
    logic [7:0]    host_wdata = '0;
    logic [7:0]    host_rdata;
    logic          rx_push = 1'b0;
    logic [7:0]    rx_data = '0;
    logic          tx_pop = 1'b0;
    logic [7:0]    tx_data;
    logic          tx_valid;
    logic [CW-1:0] rx_count, tx_count;
    logic [15:0]   divisor_o;
    logic [7:0]    line_ctrl_o, modem_ctrl_o, irq_en_o, fifo_ctrl_o, line_status_o;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;
    bit tx_drain_en = 1'b0;
    logic [7:0] rx_q[$];
    logic [7:0] tx_q[$];
    logic [7:0] rd;

    always #5 clk = ~clk;

    uart_regbank #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .rx_push(rx_push), .rx_data(rx_data), .tx_pop(tx_pop), .tx_data(tx_data),
        .tx_valid(tx_valid), .rx_count(rx_count), .tx_count(tx_count),
        .divisor_o(divisor_o), .line_ctrl_o(line_ctrl_o), .modem_ctrl_o(modem_ctrl_o),
        .irq_en_o(irq_en_o), .fifo_ctrl_o(fifo_ctrl_o), .line_status_o(line_status_o)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(posedge clk); #1;
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1 d = host_rdata;
        @(posedge clk); #1;
        host_rd = 1'b0;
    endtask

    task automatic rx_send(input logic [7:0] d, input bit expect_kept);
        @(negedge clk);
        rx_data = d; rx_push = 1'b1;
        if (expect_kept) rx_q.push_back(d);
        @(posedge clk); #1;
        rx_push = 1'b0;
    endtask

    // scoreboard consumer for the receive queue
    task automatic rx_take(input string req);
        logic [7:0] got;
        logic [7:0] exp;
        host_read(3'd0, got);
        exp = (rx_q.size() != 0) ? rx_q.pop_front() : 8'h00;
        chk(req, {8'h00, got}, {8'h00, exp});
    endtask

    task automatic rx_send_and_take(input logic [7:0] d, input string req);
        logic [7:0] got;
        logic [7:0] exp;
        @(negedge clk);
        rx_data = d; rx_push = 1'b1;
        host_addr = 3'd0; host_rd = 1'b1;
        #1 got = host_rdata;
        exp = (rx_q.size() != 0) ? rx_q.pop_front() : 8'h00;
        rx_q.push_back(d);
        chk(req, {8'h00, got}, {8'h00, exp});
        @(posedge clk); #1;
        rx_push = 1'b0; host_rd = 1'b0;
    endtask

    task automatic host_send(input logic [7:0] d);
        tx_q.push_back(d);
        host_write(3'd0, d);
    endtask

    // scoreboard monitor for the transmit queue
    always @(negedge clk) begin
        if (tx_drain_en && tx_valid) begin
            total++;
            if (tx_q.size() == 0) begin
                fails++;
                $display("FAIL R12 tx actual=%h expected=<none>", tx_data);
            end else begin
                logic [7:0] e;
                e = tx_q.pop_front();
                if (tx_data !== e) begin
                    fails++;
                    $display("FAIL R12 tx actual=%h expected=%h", tx_data, e);
                end
            end
            tx_pop <= 1'b1;
        end else begin
            tx_pop <= 1'b0;
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2 reset values
        @(negedge clk);
        chk("R2 rx_count", 16'(rx_count), 16'd0);
        chk("R2 tx_count", 16'(tx_count), 16'd0);
        chk("R2 fcr", {8'h00, fifo_ctrl_o}, 16'h00C0);
        host_read(3'd1, rd); chk("R2 ier", {8'h00, rd}, 16'h0003);
        host_read(3'd2, rd); chk("R2 ident", {8'h00, rd}, 16'h0001);
        host_read(3'd3, rd); chk("R2 lcr", {8'h00, rd}, 16'h0003);
        host_read(3'd4, rd); chk("R2 mcr", {8'h00, rd}, 16'h0000);
        host_read(3'd5, rd); chk("R2 lsr", {8'h00, rd}, 16'h0060);
        host_read(3'd6, rd); chk("R2 msr", {8'h00, rd}, 16'h0000);
        host_read(3'd7, rd); chk("R2 scr", {8'h00, rd}, 16'h0000);
        host_write(3'd3, 8'h83);
        host_read(3'd0, rd); chk("R2 dll", {8'h00, rd}, 16'h0001);
        host_read(3'd1, rd); chk("R2 dlm", {8'h00, rd}, 16'h0000);

        // R1 bank switch
        host_write(3'd0, 8'h34);
        host_write(3'd1, 8'h12);
        @(negedge clk);
        chk("R1 divisor", divisor_o, 16'h1234);
        chk("R1 no tx push", 16'(tx_count), 16'd0);
        host_read(3'd0, rd); chk("R1 dll read", {8'h00, rd}, 16'h0034);
        host_write(3'd3, 8'h03);
        host_read(3'd1, rd); chk("R1 ier kept", {8'h00, rd}, 16'h0003);

        // R10 empty read
        host_read(3'd0, rd); chk("R10 empty data", {8'h00, rd}, 16'h0000);
        @(negedge clk); chk("R10 count", 16'(rx_count), 16'd0);

        // R5 short burst
        for (int i = 0; i < 5; i++) rx_send(8'(i * 37 + 5), 1'b1);
        host_read(3'd5, rd); chk("R5 dr set", {8'h00, rd}, 16'h0061);
        for (int i = 0; i < 5; i++) rx_take("R12 rx burst");
        host_read(3'd5, rd); chk("R5 dr clear", {8'h00, rd}, 16'h0060);

        // R3 / R4 full queue
        for (int i = 0; i < DEPTH; i++) rx_send(8'(i) ^ 8'h5A, 1'b1);
        @(negedge clk); chk("R3 full count", 16'(rx_count), 16'd128);
        rx_send(8'hEE, 1'b0);
        @(negedge clk); chk("R4 drop count", 16'(rx_count), 16'd128);
        host_read(3'd5, rd); chk("R4 overrun set", {8'h00, rd}, 16'h0063);
        host_read(3'd5, rd); chk("R4 overrun clear", {8'h00, rd}, 16'h0061);
        rx_send_and_take(8'hC7, "R12 rx full swap");
        @(negedge clk); chk("R3 swap count", 16'(rx_count), 16'd128);
        host_read(3'd5, rd); chk("R3 no overrun", {8'h00, rd}, 16'h0061);
        for (int i = 0; i < DEPTH; i++) rx_take("R12 rx drain");
        host_read(3'd5, rd); chk("R5 drained", {8'h00, rd}, 16'h0060);

        // R3 simultaneous at occupancy one
        rx_send(8'h77, 1'b1);
        rx_send_and_take(8'h88, "R12 rx swap one");
        @(negedge clk); chk("R3 one count", 16'(rx_count), 16'd1);
        rx_take("R12 rx last");

        // R6 transmit path
        host_send(8'hA1); host_send(8'hB2); host_send(8'hC3);
        @(negedge clk); chk("R6 tx count", 16'(tx_count), 16'd3);
        host_read(3'd5, rd); chk("R6 busy", {8'h00, rd}, 16'h0000);
        tx_drain_en = 1'b1;
        repeat (8) @(negedge clk);
        tx_drain_en = 1'b0;
        repeat (2) @(negedge clk);
        chk("R6 tx drained", 16'(tx_count), 16'd0);
        chk("R12 tx sb empty", 16'(tx_q.size()), 16'd0);
        host_read(3'd5, rd); chk("R6 idle", {8'h00, rd}, 16'h0060);

        // R7 flush both
        for (int i = 0; i < 4; i++) rx_send(8'(i), 1'b0);
        for (int i = 0; i < 4; i++) host_write(3'd0, 8'(i + 16));
        host_write(3'd2, 8'h00);
        @(negedge clk);
        chk("R7 rx empty", 16'(rx_count), 16'd0);
        chk("R7 tx empty", 16'(tx_count), 16'd0);
        chk("R7 fcr", {8'h00, fifo_ctrl_o}, 16'h00C0);
        host_read(3'd5, rd); chk("R7 lsr kept", {8'h00, rd}, 16'h0001);
        host_read(3'd0, rd); chk("R10 after flush", {8'h00, rd}, 16'h0000);

        // R8 selective flush
        rx_send(8'h11, 1'b0); rx_send(8'h22, 1'b0);
        host_write(3'd0, 8'h33); host_write(3'd0, 8'h44);
        host_write(3'd2, 8'hC3);
        @(negedge clk);
        chk("R8 rx flushed", 16'(rx_count), 16'd0);
        chk("R8 tx kept", 16'(tx_count), 16'd2);
        chk("R8 fcr stored", {8'h00, fifo_ctrl_o}, 16'h00C1);
        host_write(3'd2, 8'h05);
        @(negedge clk);
        chk("R8 tx flushed", 16'(tx_count), 16'd0);
        chk("R8 fcr stored2", {8'h00, fifo_ctrl_o}, 16'h0001);
        host_read(3'd2, rd); chk("R11 ident", {8'h00, rd}, 16'h0001);

        // R9 writable status and scratch
        host_write(3'd5, 8'h60);
        host_read(3'd5, rd); chk("R9 lsr", {8'h00, rd}, 16'h0060);
        host_write(3'd6, 8'hA5);
        host_read(3'd6, rd); chk("R9 msr", {8'h00, rd}, 16'h00A5);
        host_write(3'd7, 8'h3C);
        host_read(3'd7, rd); chk("R9 scr", {8'h00, rd}, 16'h003C);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule